// File: doc/BRIEF.md
# Condition decode term selector

This block decides, once per clock, which of the conditions of the current step of a trigger sequencer are met. Software programs a condition word for every pair of step and condition through a simple write port. The active step number picks the set of words that apply. Each word names the input terms that take part and the level that each term must show. The candidate terms are the AND and OR outputs of four priority groups, a timer comparator and a counter comparator.

Every included term must match its programmed level for the condition to hold. A word that includes no term never holds. An optional inversion is applied last. The result is a registered hit vector with one bit per condition, and it feeds the next-step and action logic. Priority matching and the actions taken on a hit belong to other blocks.

Top module: `cond_decode_sel`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next value of `hit` is 0 and every stored condition word is cleared to 0.
- R2: When `cfg_we` is high at a rising edge, `cfg_wdata` is stored as the word for step `cfg_step`, condition `cfg_cond`. The new word is used from the following edge on. A write to a step other than `cur_step` leaves `hit` unchanged.
- R3: The words used for `hit` are the `NUM_CONDS` words stored for step `cur_step`. Bit c of `hit` belongs to condition c.
- R4: For priority group n (0..3), word bit 4n+1 includes `prio_and[n]` as a term, and word bit 4n gives its required level (1 = high, 0 = low).
- R5: For priority group n, word bit 4n+3 includes `prio_or[n]` as a term, and word bit 4n+2 gives its required level.
- R6: Word bit 17 includes `timer_cmp` as a term, and bit 16 gives its required level.
- R7: Word bit 21 includes `count_cmp` as a term, and bit 20 gives its required level.
- R8: A condition holds when every included term equals its required level. Terms that are not included have no effect.
- R9: A word with none of the include bits (4n+1, 4n+3, 17, 21) set decodes as false before the inversion.
- R10: Word bit 24 inverts the decoded result of its condition, after all terms have been combined.
- R11: `hit` is registered. It shows the decode of the inputs and words present at the previous rising edge, and it does not change while those stay constant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Write strobe for a condition word |
| cfg_step | input | STEP_W (2) | Step index of the word being written |
| cfg_cond | input | COND_W (2) | Condition index of the word being written |
| cfg_wdata | input | WORD_W (32) | Condition word to store |
| cur_step | input | STEP_W (2) | Step currently active in the sequencer |
| prio_and | input | 4 | AND outputs of the four priority groups |
| prio_or | input | 4 | OR outputs of the four priority groups |
| timer_cmp | input | 1 | Timer comparator output |
| count_cmp | input | 1 | Counter comparator output |
| hit | output | NUM_CONDS (4) | Registered decode result, one bit per condition |

## Verification
The bench goes after the empty word, both alone and with the inversion bit. A design that treats an AND over zero terms as true would fire every unprogrammed condition, and one that inverts before combining would get the empty-plus-NOT case wrong. It checks a term required low, an OR output required low next to AND outputs required high, and a word that includes all ten terms, so that a swapped level or include bit or a crossed group index shows up as a wrong hit bit. It writes to a step that is not active and confirms that the hit vector does not move. It also checks the exact cycle at which a write or an input change reaches `hit`, which catches a missing register or an extra one.

// File: rtl/cond_decode_pkg.sv
// Package: shared constants and helpers for the condition decode term selector.
// Assumes the word layout: group n uses bits 4n..4n+3, the timer uses bits 16/17,
// the counter uses bits 20/21 and the inversion uses bit 24.
package cond_decode_pkg;

    localparam int NUM_GROUPS  = 4;
    localparam int NUM_TERMS   = 2 * NUM_GROUPS + 2;
    localparam int TMR_LVL_BIT = 16;
    localparam int TMR_INC_BIT = 17;
    localparam int CNT_LVL_BIT = 20;
    localparam int CNT_INC_BIT = 21;
    localparam int INV_BIT     = 24;
    localparam int MIN_WORD_W  = INV_BIT + 1;

    // Bit position of the required level of group n's AND output.
    function automatic int and_lvl_bit(input int n);
        return 4 * n;
    endfunction

    // Bit position of the include flag of group n's AND output.
    function automatic int and_inc_bit(input int n);
        return 4 * n + 1;
    endfunction

    // Bit position of the required level of group n's OR output.
    function automatic int or_lvl_bit(input int n);
        return 4 * n + 2;
    endfunction

    // Bit position of the include flag of group n's OR output.
    function automatic int or_inc_bit(input int n);
        return 4 * n + 3;
    endfunction

    // Mask of every include flag, for a 32-bit word.
    function automatic logic [31:0] include_mask();
        logic [31:0] m;
        m = '0;
        for (int n = 0; n < NUM_GROUPS; n++) begin
            m[and_inc_bit(n)] = 1'b1;
            m[or_inc_bit(n)]  = 1'b1;
        end
        m[TMR_INC_BIT] = 1'b1;
        m[CNT_INC_BIT] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/cond_word_store.sv
// Module: cond_word_store
// Holds one condition word per (step, condition) pair and presents the words of
// the selected step. Assumes NUM_STEPS and NUM_CONDS are at least 2. Writes take
// effect at the clock edge. The read side is combinational from the stored words.
module cond_word_store #(
    parameter int NUM_STEPS = 4,
    parameter int NUM_CONDS = 4,
    parameter int WORD_W    = 32,
    localparam int STEP_W   = $clog2(NUM_STEPS),
    localparam int COND_W   = $clog2(NUM_CONDS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [STEP_W-1:0]                wr_step,
    input  logic [COND_W-1:0]                wr_cond,
    input  logic [WORD_W-1:0]                wr_data,
    input  logic [STEP_W-1:0]                rd_step,
    output logic [NUM_CONDS-1:0][WORD_W-1:0] rd_words
);

    logic [WORD_W-1:0] words_q [NUM_STEPS][NUM_CONDS];

    // Store a written word, and clear every word on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_STEPS; s++) begin
                for (int c = 0; c < NUM_CONDS; c++) begin
                    words_q[s][c] <= '0;
                end
            end
        end else if (wr_en && (int'(wr_step) < NUM_STEPS) && (int'(wr_cond) < NUM_CONDS)) begin
            words_q[wr_step][wr_cond] <= wr_data;
        end
    end

    // Present the words of the selected step; a step beyond range reads as empty.
    generate
        for (genvar c = 0; c < NUM_CONDS; c++) begin : g_rd
            always_comb begin
                if (int'(rd_step) < NUM_STEPS) begin
                    rd_words[c] = words_q[rd_step][c];
                end else begin
                    rd_words[c] = '0;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/cond_term_eval.sv
// Module: cond_term_eval
// Purely combinational decode of one condition word against the term inputs.
// Every included term must equal its required level. A word that includes no
// term is false. The inversion bit is applied to the combined result last.
module cond_term_eval
    import cond_decode_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0]     word,
    input  logic [NUM_GROUPS-1:0] prio_and,
    input  logic [NUM_GROUPS-1:0] prio_or,
    input  logic                  timer_cmp,
    input  logic                  count_cmp,
    output logic                  cond_true
);

    logic [NUM_TERMS-1:0] term_val;
    logic [NUM_TERMS-1:0] term_inc;
    logic [NUM_TERMS-1:0] term_lvl;
    logic [NUM_TERMS-1:0] term_ok;
    logic                 any_inc;
    logic                 all_ok;
    logic                 unused_word;

    // Gather the per-group terms: slot 2n is the AND output, slot 2n+1 the OR output.
    generate
        for (genvar n = 0; n < NUM_GROUPS; n++) begin : g_grp
            assign term_val[2*n]   = prio_and[n];
            assign term_inc[2*n]   = word[and_inc_bit(n)];
            assign term_lvl[2*n]   = word[and_lvl_bit(n)];
            assign term_val[2*n+1] = prio_or[n];
            assign term_inc[2*n+1] = word[or_inc_bit(n)];
            assign term_lvl[2*n+1] = word[or_lvl_bit(n)];
        end
    endgenerate

    // The two comparator terms fill the last two slots.
    assign term_val[NUM_TERMS-2] = timer_cmp;
    assign term_inc[NUM_TERMS-2] = word[TMR_INC_BIT];
    assign term_lvl[NUM_TERMS-2] = word[TMR_LVL_BIT];
    assign term_val[NUM_TERMS-1] = count_cmp;
    assign term_inc[NUM_TERMS-1] = word[CNT_INC_BIT];
    assign term_lvl[NUM_TERMS-1] = word[CNT_LVL_BIT];

    // A term passes when it is left out or shows its required level.
    always_comb begin
        term_ok = ~term_inc | ~(term_val ^ term_lvl);
        any_inc = |term_inc;
        all_ok  = &term_ok;
    end

    // Combine, force the empty word to false, then apply the inversion.
    assign cond_true = (any_inc & all_ok) ^ word[INV_BIT];

    // Reserved bits of the word take no part in the decode.
    assign unused_word = ^word;

endmodule

// File: rtl/cond_decode_sel.sv
// Module: cond_decode_sel (top)
// Selects the condition words of the current step, decodes each one against the
// priority-group and comparator terms, and registers the hit vector. Assumes
// WORD_W >= 25, and that the inputs are synchronous to clk.
module cond_decode_sel
    import cond_decode_pkg::*;
#(
    parameter int NUM_STEPS = 4,
    parameter int NUM_CONDS = 4,
    parameter int WORD_W    = 32,
    localparam int STEP_W   = $clog2(NUM_STEPS),
    localparam int COND_W   = $clog2(NUM_CONDS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [STEP_W-1:0]     cfg_step,
    input  logic [COND_W-1:0]     cfg_cond,
    input  logic [WORD_W-1:0]     cfg_wdata,
    input  logic [STEP_W-1:0]     cur_step,
    input  logic [NUM_GROUPS-1:0] prio_and,
    input  logic [NUM_GROUPS-1:0] prio_or,
    input  logic                  timer_cmp,
    input  logic                  count_cmp,
    output logic [NUM_CONDS-1:0]  hit
);

    logic [NUM_CONDS-1:0][WORD_W-1:0] cur_words;
    logic [NUM_CONDS-1:0]             hit_d;

    // Storage for all condition words, read out for the current step.
    cond_word_store #(
        .NUM_STEPS(NUM_STEPS),
        .NUM_CONDS(NUM_CONDS),
        .WORD_W   (WORD_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_step (cfg_step),
        .wr_cond (cfg_cond),
        .wr_data (cfg_wdata),
        .rd_step (cur_step),
        .rd_words(cur_words)
    );

    // One decoder per condition of the current step.
    generate
        for (genvar c = 0; c < NUM_CONDS; c++) begin : g_cond
            cond_term_eval #(
                .WORD_W(WORD_W)
            ) u_eval (
                .word     (cur_words[c]),
                .prio_and (prio_and),
                .prio_or  (prio_or),
                .timer_cmp(timer_cmp),
                .count_cmp(count_cmp),
                .cond_true(hit_d[c])
            );
        end
    endgenerate

    // Register the hit vector; reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit <= '0;
        end else begin
            hit <= hit_d;
        end
    end

endmodule

// File: rtl/cond_decode_chk.sv
// Module: cond_decode_chk
// Property checker bound to cond_decode_sel. It watches the ports and the words
// read for the current step, and checks reset, empty-word, inversion,
// comparator-mismatch and hold behaviour of the registered hit vector.
module cond_decode_chk
    import cond_decode_pkg::*;
#(
    parameter int NUM_STEPS = 4,
    parameter int NUM_CONDS = 4,
    parameter int WORD_W    = 32,
    localparam int STEP_W   = $clog2(NUM_STEPS)
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             cfg_we,
    input logic [STEP_W-1:0]                cur_step,
    input logic [NUM_GROUPS-1:0]            prio_and,
    input logic [NUM_GROUPS-1:0]            prio_or,
    input logic                             timer_cmp,
    input logic                             count_cmp,
    input logic [NUM_CONDS-1:0][WORD_W-1:0] cur_words,
    input logic [NUM_CONDS-1:0]             hit
);

    localparam logic [31:0] INC_MASK = include_mask();

    logic started_q;
    logic rst_seen_q;

    // Track that one edge has passed and whether reset was low at the last edge.
    always_ff @(posedge clk) begin
        started_q  <= 1'b1;
        rst_seen_q <= !rst_n;
    end

    // R1: the edge after a reset edge leaves hit at zero.
    always_ff @(posedge clk) begin
        if (started_q === 1'b1 && rst_seen_q === 1'b1) begin
            assert_reset_clear_R1: assert (hit == '0)
                else $error("hit not cleared after reset");
        end
    end

    // R11: with inputs, step and words unchanged, hit holds.
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cfg_we) && $stable(cur_step) && $stable(prio_and) &&
         $stable(prio_or) && $stable(timer_cmp) && $stable(count_cmp))
        |=> $stable(hit));

    generate
        for (genvar c = 0; c < NUM_CONDS; c++) begin : g_c
            // R9: an empty word without inversion never fires.
            assert_empty_false_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (((32'(cur_words[c]) & INC_MASK) == '0) && !cur_words[c][INV_BIT])
                |=> !hit[c]);

            // R10: an empty word with inversion always fires.
            assert_empty_inverted_R10: assert property (@(posedge clk) disable iff (!rst_n)
                (((32'(cur_words[c]) & INC_MASK) == '0) && cur_words[c][INV_BIT])
                |=> hit[c]);

            // R6: an included timer term at the wrong level blocks a non-inverted hit.
            assert_timer_mismatch_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (cur_words[c][TMR_INC_BIT] && (cur_words[c][TMR_LVL_BIT] != timer_cmp) &&
                 !cur_words[c][INV_BIT])
                |=> !hit[c]);

            // R7: an included counter term at the wrong level blocks a non-inverted hit.
            assert_counter_mismatch_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (cur_words[c][CNT_INC_BIT] && (cur_words[c][CNT_LVL_BIT] != count_cmp) &&
                 !cur_words[c][INV_BIT])
                |=> !hit[c]);
        end
    endgenerate

endmodule

bind cond_decode_sel cond_decode_chk #(
    .NUM_STEPS(NUM_STEPS),
    .NUM_CONDS(NUM_CONDS),
    .WORD_W   (WORD_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cur_step (cur_step),
    .prio_and (prio_and),
    .prio_or  (prio_or),
    .timer_cmp(timer_cmp),
    .count_cmp(count_cmp),
    .cur_words(cur_words),
    .hit      (hit)
);

// File: tb/tb_cond_decode_sel.sv
`timescale 1ns/1ps
// Bench for cond_decode_sel: programs a fixed set of words, walks a vector
// table, then runs directed cases for write effects, latency and reset.
module tb_cond_decode_sel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_step = '0;
    logic [1:0]  cfg_cond = '0;
    logic [31:0] cfg_wdata = '0;
    logic [1:0]  cur_step = '0;
    logic [3:0]  prio_and = '0;
    logic [3:0]  prio_or = '0;
    logic        timer_cmp = 1'b0;
    logic        count_cmp = 1'b0;
    logic [3:0]  hit;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cond_decode_sel dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_step (cfg_step),
        .cfg_cond (cfg_cond),
        .cfg_wdata(cfg_wdata),
        .cur_step (cur_step),
        .prio_and (prio_and),
        .prio_or  (prio_or),
        .timer_cmp(timer_cmp),
        .count_cmp(count_cmp),
        .hit      (hit)
    );

    // Vector fields: {step[2], and[4], or[4], timer, counter, expected hit[4]}.
    localparam logic [15:0] VECS [12] = '{
        {2'd0, 4'b0001, 4'b0000, 1'b0, 1'b0, 4'b1001},
        {2'd0, 4'b0010, 4'b0000, 1'b0, 1'b0, 4'b1010},
        {2'd0, 4'b0011, 4'b0000, 1'b0, 1'b0, 4'b1011},
        {2'd0, 4'b0000, 4'b1111, 1'b1, 1'b1, 4'b1000},
        {2'd1, 4'b0000, 4'b0000, 1'b1, 1'b0, 4'b0101},
        {2'd1, 4'b0000, 4'b0001, 1'b0, 1'b0, 4'b0010},
        {2'd1, 4'b1111, 4'b0000, 1'b1, 1'b1, 4'b1101},
        {2'd1, 4'b1111, 4'b1000, 1'b1, 1'b1, 4'b0101},
        {2'd1, 4'b1111, 4'b0001, 1'b1, 1'b0, 4'b0001},
        {2'd2, 4'b0000, 4'b1000, 1'b0, 1'b0, 4'b0011},
        {2'd2, 4'b0100, 4'b0111, 1'b1, 1'b1, 4'b0000},
        {2'd3, 4'b1111, 4'b1111, 1'b1, 1'b1, 4'b0001}
    };

    // Compare hit with its expected value and report a mismatch.
    task automatic check_hit(input string what, input logic [3:0] exp);
        checks++;
        if (hit !== exp) begin
            failures++;
            $display("FAIL %s: hit=%b expected=%b", what, hit, exp);
        end
    endtask

    // Write one condition word; returns at the falling edge after the write edge.
    task automatic write_word(input logic [1:0] s, input logic [1:0] c, input logic [31:0] d);
        cfg_we    = 1'b1;
        cfg_step  = s;
        cfg_cond  = c;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Drive the term inputs and the step.
    task automatic drive(input logic [1:0] s, input logic [3:0] a, input logic [3:0] o,
                         input logic t, input logic k);
        cur_step  = s;
        prio_and  = a;
        prio_or   = o;
        timer_cmp = t;
        count_cmp = k;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(4 * 20000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_hit("R1 reset state", 4'b0000);
        rst_n = 1'b1;

        // Step 0: AND0 high, AND1 high, empty, empty+NOT.
        write_word(2'd0, 2'd0, 32'h0000_0003);
        write_word(2'd0, 2'd1, 32'h0000_0030);
        write_word(2'd0, 2'd3, 32'h0100_0000);
        // Step 1: timer high, timer low, NOT(OR0 high & counter low), all ten terms.
        write_word(2'd1, 2'd0, 32'h0003_0000);
        write_word(2'd1, 2'd1, 32'h0002_0000);
        write_word(2'd1, 2'd2, 32'h0120_000C);
        write_word(2'd1, 2'd3, 32'h0033_BBBB);
        // Step 2: OR3 high, AND2 low.
        write_word(2'd2, 2'd0, 32'h0000_C000);
        write_word(2'd2, 2'd1, 32'h0000_0200);
        // Step 3: empty+NOT in condition 0 only.
        write_word(2'd3, 2'd0, 32'h0100_0000);

        // Table walk: R3 R4 R5 R6 R7 R8 R9 R10 under distinct patterns.
        for (int i = 0; i < 12; i++) begin
            drive(VECS[i][15:14], VECS[i][13:10], VECS[i][9:6], VECS[i][5], VECS[i][4]);
            @(negedge clk);
            check_hit($sformatf("vector %0d (R3 R4 R5 R6 R7 R8 R9 R10)", i), VECS[i][3:0]);
        end

        // R2: a write to an inactive step leaves hit unchanged.
        drive(2'd0, 4'b0001, 4'b0000, 1'b1, 1'b0);
        @(negedge clk);
        check_hit("R2 before off-step write", 4'b1001);
        write_word(2'd1, 2'd0, 32'h0000_0000);
        @(negedge clk);
        check_hit("R2 off-step write ignored", 4'b1001);
        drive(2'd1, 4'b0001, 4'b0000, 1'b1, 1'b0);
        @(negedge clk);
        check_hit("R2 rewritten word used", 4'b0100);

        // R11 and R2: a write reaches hit one edge after the write edge.
        drive(2'd0, 4'b0000, 4'b0000, 1'b0, 1'b0);
        @(negedge clk);
        check_hit("R11 settle step 0", 4'b1000);
        write_word(2'd0, 2'd2, 32'h0000_0002);
        check_hit("R11 hit at write edge still old", 4'b1000);
        @(negedge clk);
        check_hit("R2 new word (AND0 low) in effect", 4'b1100);

        // R11: an input change is not seen before the next edge.
        prio_and = 4'b0001;
        #1;
        check_hit("R11 no combinational path", 4'b1100);
        @(negedge clk);
        check_hit("R11 input change after one edge", 4'b1001);

        // R1: reset in mid-run clears hit and every word.
        drive(2'd0, 4'b1111, 4'b1111, 1'b1, 1'b1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check_hit("R1 hit cleared in reset", 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        check_hit("R1 words cleared, all-ones inputs", 4'b0000);
        drive(2'd3, 4'b0000, 4'b0000, 1'b0, 1'b0);
        @(negedge clk);
        check_hit("R1 words cleared, step 3 NOT gone", 4'b0000);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule